// File: doc/BRIEF.md
# Compression-Tree Integer Multiplier

This block multiplies two W-bit integers and returns the full 2W-bit product. It first forms the W×W matrix of AND terms. It then reduces every bit column of that matrix to at most two bits, using counter cells, and adds the two surviving rows in one carry-propagate adder. A runtime input selects unsigned or two's-complement signed operation, and the same hardware serves both. In signed mode, the terms that pair exactly one sign bit with a non-sign bit are inverted, and a constant one is added at weights W and 2W-1.

The reduction visits the columns from least to most significant. Inside a column it keeps applying cells until two bits or fewer remain:
- A column holding more than four bits uses a 4:2 cell when the `QUAD` parameter is set.
- Otherwise, a column holding more than three bits uses a full adder.
- Otherwise, a column holding exactly three bits uses a half adder.

A 4:2 cell is built from two chained full adders. The first adder's carry leaves sideways as a pending bit for the next column. The second adder takes the first adder's sum, the fourth bit, and one pending sideways bit from the column below, or zero when none is pending. Any pending sideways bits that no 4:2 cell consumes join the column as ordinary bits. Every sum stays in its own column. Every carry moves one column up, and carries leaving the top column are discarded.

With `PIPE` set, a register holds the two reduced rows. That register clears on reset, loads when enable is high and holds otherwise. The product then appears one cycle after its operands. With `PIPE` clear, the block is fully combinational.

Top module: `cmpr_mult`

## Requirements
- R1: With `sgn_sel` = 0, `prod` equals the unsigned product of `opa` and `opb` (both operands zero-extended, result taken modulo 2^(2W)).
- R2: With `sgn_sel` = 1, `prod` equals the two's-complement product of `opa` and `opb`, with both read as signed W-bit values and the result taken modulo 2^(2W).
- R3: Results are identical whether `QUAD` is 1 (4:2, 3:2 and 2:2 cells) or 0 (3:2 and 2:2 cells only), and after reduction no column holds more than two bits.
- R4: With `PIPE` = 1, operands presented before a rising edge with `en` = 1 show up on `prod` after that edge, and a new operand pair can be accepted on every cycle.
- R5: With `PIPE` = 1, a rising edge with `en` = 0 leaves `prod` unchanged, whatever the operands or `sgn_sel` do.
- R6: With `PIPE` = 1, a rising edge with `rst` = 1 sets `prod` to zero, even when `en` = 1. Reset has priority over loading.
- R7: With `PIPE` = 0, `prod` follows the operands and `sgn_sel` with no clock edge in between.
- R8: Corner operands give exact results in both modes: zero, all ones (unsigned maximum, signed -1) and the most negative signed value 100…0, including most-negative times most-negative.
- R9: Toggling `sgn_sel` on consecutive cycles while the operands stay fixed switches `prod` between the unsigned and the signed reading of the same bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional row register |
| rst | input | 1 | Synchronous active-high clear of the row register |
| en | input | 1 | Load enable of the row register |
| opa | input | W | Multiplicand |
| opb | input | W | Multiplier |
| sgn_sel | input | 1 | 1 = signed two's-complement operation, 0 = unsigned |
| prod | output | 2W | Product |

## Verification
The row register can see reset and a load request in the same cycle. The bench provokes this by raising `rst` together with `en` and a fresh operand pair, after a non-zero product has been loaded. Reset must win, so `prod` must read zero after that edge. After reset falls, the still-applied operands must load on the next edge. A second overlap occurs when the signedness select and the hold condition change together. The bench flips the operands and `sgn_sel` while `en` is low. It then judges that the registered product keeps the old value, while the combinational instance already shows the new signed or unsigned result.

// File: rtl/cmpr_pkg.sv
package cmpr_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } add_res_t;

    function automatic add_res_t fadd(input logic x, input logic y, input logic z);
        add_res_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    function automatic add_res_t hadd(input logic x, input logic y);
        add_res_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

endpackage

// File: rtl/cmpr_ppgen.sv
module cmpr_ppgen #(
    parameter int W = 8
) (
    input  logic [W-1:0]          opa,
    input  logic [W-1:0]          opb,
    input  logic                  sgn,
    output logic [W-1:0][W-1:0]   pp
);
    // Row i is weighted by opb[i]; column j by opa[j].
    // In signed mode, terms that pair exactly one sign bit with a
    // non-sign bit are inverted; the correction ones are added in
    // the reduction stage.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                pp[i][j] = (opa[j] & opb[i])
                         ^ (sgn & ((i == W-1) != (j == W-1)));
            end
        end
    end

endmodule

// File: rtl/cmpr_reduce.sv
module cmpr_reduce
    import cmpr_pkg::*;
#(
    parameter int W    = 8,
    parameter bit QUAD = 1'b1
) (
    input  logic [W-1:0][W-1:0] pp,
    input  logic                sgn,
    output logic [2*W-1:0]      row0,
    output logic [2*W-1:0]      row1
);
    localparam int NC  = 2 * W;
    localparam int IW  = $clog2(6 * W + 16);
    localparam int CAP = 2 ** IW;

    logic red_ok;

    always_comb begin : p_sched
        logic [CAP-1:0] q   [NC];
        logic [IW-1:0]  hd  [NC];
        logic [IW-1:0]  tl  [NC];
        logic [CAP-1:0] cur;
        logic [CAP-1:0] nxt;
        logic [IW-1:0]  cur_n;
        logic [IW-1:0]  cur_hd;
        logic [IW-1:0]  nxt_n;
        logic [IW-1:0]  n;
        logic           t0, t1, t2, t3, ci;
        add_res_t       f1, f2;

        row0   = '0;
        row1   = '0;
        red_ok = 1'b1;
        cur    = '0;
        nxt    = '0;
        cur_n  = '0;
        cur_hd = '0;
        nxt_n  = '0;
        n      = '0;
        {t0, t1, t2, t3, ci} = '0;
        f1 = '0;
        f2 = '0;
        for (int c = 0; c < NC; c++) begin
            q[c]  = '0;
            hd[c] = '0;
            tl[c] = '0;
        end

        // Load the matrix into per-column queues.
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                q[i+j][tl[i+j]] = pp[i][j];
                tl[i+j]         = tl[i+j] + IW'(1);
            end
        end
        // Signed-mode correction ones at weights W and 2W-1.
        q[W][tl[W]]           = sgn;
        tl[W]                 = tl[W] + IW'(1);
        q[NC-1][tl[NC-1]]     = sgn;
        tl[NC-1]              = tl[NC-1] + IW'(1);

        // Column schedule, least significant first.
        for (int c = 0; c < NC; c++) begin
            nxt    = '0;
            nxt_n  = '0;
            cur_hd = '0;
            for (int it = 0; it < CAP; it++) begin
                n = tl[c] - hd[c];
                if (QUAD && (n > IW'(4))) begin
                    t0 = q[c][hd[c]];
                    t1 = q[c][hd[c] + IW'(1)];
                    t2 = q[c][hd[c] + IW'(2)];
                    t3 = q[c][hd[c] + IW'(3)];
                    hd[c] = hd[c] + IW'(4);
                    if (cur_hd < cur_n) begin
                        ci     = cur[cur_hd];
                        cur_hd = cur_hd + IW'(1);
                    end else begin
                        ci = 1'b0;
                    end
                    f1 = fadd(t1, t2, t3);
                    f2 = fadd(f1.s, t0, ci);
                    q[c][tl[c]] = f2.s;
                    tl[c]       = tl[c] + IW'(1);
                    if (c < NC - 1) begin
                        q[c+1][tl[c+1]] = f2.c;
                        tl[c+1]         = tl[c+1] + IW'(1);
                        nxt[nxt_n]      = f1.c;
                        nxt_n           = nxt_n + IW'(1);
                    end
                end else if (n > IW'(3)) begin
                    f1 = fadd(q[c][hd[c]], q[c][hd[c] + IW'(1)], q[c][hd[c] + IW'(2)]);
                    hd[c] = hd[c] + IW'(3);
                    q[c][tl[c]] = f1.s;
                    tl[c]       = tl[c] + IW'(1);
                    if (c < NC - 1) begin
                        q[c+1][tl[c+1]] = f1.c;
                        tl[c+1]         = tl[c+1] + IW'(1);
                    end
                end else if (n > IW'(2)) begin
                    f1 = hadd(q[c][hd[c]], q[c][hd[c] + IW'(1)]);
                    hd[c] = hd[c] + IW'(2);
                    q[c][tl[c]] = f1.s;
                    tl[c]       = tl[c] + IW'(1);
                    if (c < NC - 1) begin
                        q[c+1][tl[c+1]] = f1.c;
                        tl[c+1]         = tl[c+1] + IW'(1);
                    end
                end else if (cur_hd < cur_n) begin
                    // Unused sideways carry joins the column.
                    q[c][tl[c]] = cur[cur_hd];
                    tl[c]       = tl[c] + IW'(1);
                    cur_hd      = cur_hd + IW'(1);
                end
            end
            n = tl[c] - hd[c];
            if (n > IW'(0)) row0[c] = q[c][hd[c]];
            if (n > IW'(1)) row1[c] = q[c][hd[c] + IW'(1)];
            if ((n > IW'(2)) || (cur_hd != cur_n)) red_ok = 1'b0;
            cur   = nxt;
            cur_n = nxt_n;
        end
    end

    // Every column must end with at most two bits and no pending carry.
    always_comb begin
        p_two_rows_r3: assert (red_ok)
            else $error("reduction left a column taller than two");
    end

endmodule

// File: rtl/cmpr_stage.sv
module cmpr_stage #(
    parameter int NC   = 16,
    parameter bit PIPE = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [NC-1:0] r0_i,
    input  logic [NC-1:0] r1_i,
    output logic [NC-1:0] r0_o,
    output logic [NC-1:0] r1_o
);
    generate
        if (PIPE) begin : g_reg
            typedef struct packed {
                logic [NC-1:0] r0;
                logic [NC-1:0] r1;
            } rows_t;

            rows_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (en) begin
                    st_d.r0 = r0_i;
                    st_d.r1 = r1_i;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign r0_o = st_q.r0;
            assign r1_o = st_q.r1;
        end else begin : g_wire
            assign r0_o = r0_i;
            assign r1_o = r1_i;
        end
    endgenerate

endmodule

// File: rtl/cmpr_mult.sv
module cmpr_mult #(
    parameter int W    = 8,
    parameter bit QUAD = 1'b1,
    parameter bit PIPE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic             sgn_sel,
    output logic [2*W-1:0]   prod
);
    localparam int NC = 2 * W;

    logic [W-1:0][W-1:0] pp;
    logic [NC-1:0]       red0, red1;
    logic [NC-1:0]       stg0, stg1;

    cmpr_ppgen #(.W(W)) u_ppgen (
        .opa (opa),
        .opb (opb),
        .sgn (sgn_sel),
        .pp  (pp)
    );

    cmpr_reduce #(.W(W), .QUAD(QUAD)) u_reduce (
        .pp   (pp),
        .sgn  (sgn_sel),
        .row0 (red0),
        .row1 (red1)
    );

    cmpr_stage #(.NC(NC), .PIPE(PIPE)) u_stage (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .r0_i (red0),
        .r1_i (red1),
        .r0_o (stg0),
        .r1_o (stg1)
    );

    // Final carry-propagate adder.
    assign prod = stg0 + stg1;

    // Behavioural references used only by the checks below.
    logic [NC-1:0] ref_u, ref_s;
    assign ref_u = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
    assign ref_s = {{W{opa[W-1]}}, opa} * {{W{opb[W-1]}}, opb};

    generate
        if (PIPE) begin : g_chk_reg
            p_unsigned_r1: assert property (@(posedge clk) disable iff (rst)
                (en && !sgn_sel) |=> (prod == $past(ref_u)));
            p_signed_r2: assert property (@(posedge clk) disable iff (rst)
                (en && sgn_sel) |=> (prod == $past(ref_s)));
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(prod));
        end else begin : g_chk_comb
            p_comb_r7: assert property (@(posedge clk) disable iff (rst)
                prod == (sgn_sel ? ref_s : ref_u));
        end
    endgenerate

endmodule

// File: tb/sim_cmpr_mult.sv
`timescale 1ns/1ps
module sim_cmpr_mult;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en  = 1'b0;
    logic [W-1:0]   opa = '0;
    logic [W-1:0]   opb = '0;
    logic           sel = 1'b0;
    logic [2*W-1:0] prod0, prod1;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    // Pipelined, 4:2 cells enabled.
    cmpr_mult #(.W(W), .QUAD(1'b1), .PIPE(1'b1)) u0 (
        .clk(clk), .rst(rst), .en(en), .opa(opa), .opb(opb),
        .sgn_sel(sel), .prod(prod0)
    );

    // Combinational, full and half adders only.
    cmpr_mult #(.W(W), .QUAD(1'b0), .PIPE(1'b0)) u1 (
        .clk(clk), .rst(rst), .en(en), .opa(opa), .opb(opb),
        .sgn_sel(sel), .prod(prod1)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x,
                                               input logic [W-1:0] y,
                                               input logic s);
        logic [2*W-1:0] xe, ye;
        xe = s ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
        ye = s ? {{W{y[W-1]}}, y} : {{W{1'b0}}, y};
        return xe * ye;
    endfunction

    task automatic chk(input string tag, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operand pair; check the comb copy at once, the registered copy one edge later.
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic s, input string tag);
        @(negedge clk);
        opa = x; opb = y; sel = s; en = 1'b1;
        #1 chk({tag, " comb R3 R7"}, prod1, ref_mul(x, y, s));
        @(negedge clk);
        chk({tag, " pipe R3 R4"}, prod0, ref_mul(x, y, s));
    endtask

    task automatic t_reset;
        rst = 1'b1; en = 1'b1; opa = 8'h5A; opb = 8'hC3;
        repeat (3) @(negedge clk);
        chk("R6 reset state", prod0, '0);
        rst = 1'b0;
    endtask

    task automatic t_corners;
        logic [W-1:0] v [4];
        v[0] = '0; v[1] = '1; v[2] = {1'b1, {(W-1){1'b0}}}; v[3] = 8'h01;
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    drive(v[i], v[j], s[0], s[0] ? "R8 R2 corner" : "R8 R1 corner");
                end
            end
        end
    endtask

    task automatic t_random;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 150; k++) begin
                drive(W'($urandom), W'($urandom), s[0],
                      s[0] ? "R2 random" : "R1 random");
            end
        end
    endtask

    task automatic t_stream;
        logic [W-1:0] xa [8];
        logic [W-1:0] xb [8];
        for (int k = 0; k < 8; k++) begin
            xa[k] = W'($urandom); xb[k] = W'($urandom);
        end
        @(negedge clk);
        en = 1'b1; sel = 1'b1;
        opa = xa[0]; opb = xb[0];
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            chk("R4 back-to-back", prod0, ref_mul(xa[k-1], xb[k-1], 1'b1));
            opa = xa[k]; opb = xb[k];
        end
        @(negedge clk);
        chk("R4 back-to-back last", prod0, ref_mul(xa[7], xb[7], 1'b1));
    endtask

    task automatic t_hold;
        drive(8'hD7, 8'h6B, 1'b0, "R1 before hold");
        en = 1'b0; opa = 8'h91; opb = 8'hFE; sel = 1'b1;
        #1 chk("R7 comb follows during hold", prod1, ref_mul(8'h91, 8'hFE, 1'b1));
        @(negedge clk);
        chk("R5 hold first edge", prod0, ref_mul(8'hD7, 8'h6B, 1'b0));
        @(negedge clk);
        chk("R5 hold second edge", prod0, ref_mul(8'hD7, 8'h6B, 1'b0));
        en = 1'b1;
        @(negedge clk);
        chk("R4 load after hold", prod0, ref_mul(8'h91, 8'hFE, 1'b1));
    endtask

    task automatic t_reset_load;
        drive(8'hFF, 8'h7F, 1'b0, "R1 before reset");
        rst = 1'b1; en = 1'b1; opa = 8'h33; opb = 8'h85; sel = 1'b1;
        @(negedge clk);
        chk("R6 reset beats load", prod0, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 load after reset", prod0, ref_mul(8'h33, 8'h85, 1'b1));
    endtask

    task automatic t_sel_toggle;
        @(negedge clk);
        en = 1'b1; opa = 8'hF3; opb = 8'h85;
        for (int k = 0; k < 6; k++) begin
            sel = k[0];
            #1 chk("R9 comb toggle", prod1, ref_mul(8'hF3, 8'h85, k[0]));
            @(negedge clk);
            chk("R9 pipe toggle", prod0, ref_mul(8'hF3, 8'h85, k[0]));
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_random();
        t_stream();
        t_hold();
        t_reset_load();
        t_sel_toggle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule